// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a register port and a non-volatile storage array and decides when a flash operation may start and when it ends. Software picks an enable mode, then asks for a word program, a page erase, a partial page erase, an info-page erase or an erase of the whole array. The sequencer accepts a request only if the mode allows it and no operation is running. It then loads a cycle timer with that operation's duration and holds two status bits low until the timer runs out.

When the timer expires, the block sends a single-cycle completion pulse to the array. The pulse carries an operation code, the target page and, for a program, the word index and data. The array applies the change at that moment. A build parameter selects how erases are started. In one variant they are started from address registers. In the other, a program of an all-ones word to the first word of a page is turned into a page erase or a partial erase.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `ready` and `ready_next` are 1 and `range_err` is 0. The mode register (offset 0) reads 0 and the partial-erase duration register (offset 5) reads 10. The status register (offset 6: bit0 ready, bit1 ready_next, bit2 range error) reads 3.
- R2: Mode register offset 0, bits [1:0]: 0 read-only, 1 program, 2 erase, 3 partial erase. A program starts only in mode 1. Page erase, info-page erase and erase-all start only in mode 2. Partial erase starts only in mode 3. In any other mode the request has no effect and `ready` stays 1.
- R3: A request that arrives while an operation runs is dropped. The running operation keeps its code and its timing, and no extra completion pulse appears.
- R4: In the cycle after a request is accepted, `ready` and `ready_next` both read 0. They return to 1 together, in the same cycle as the completion pulse.
- R5: The info-page erase trigger (offset 3) and the erase-all trigger (offset 4) look only at bit 0. A write with bit 0 clear does nothing. Both offsets read back 0.
- R6: The completion pulse comes a set number of cycles after the accept edge: T_WRITE for a program, T_PAGE for a page erase or an info-page erase, T_ALL for an erase-all, and (offset 5 value × PART_UNIT) for a partial erase, with a minimum of 1.
- R7: Writing a byte address to offset 1 requests a page erase, and writing one to offset 2 requests a partial erase. The page index is (address − FLASH_BASE) / PAGE_BYTES, so an address that is not aligned erases the page that contains it.
- R8: With ERASE_REGS = 0, offsets 1 to 3 start nothing. A program of 0xFFFFFFFF to a page-aligned flash address starts a page erase in mode 2 or a partial erase in mode 3, and is an ordinary program in mode 1. With ERASE_REGS = 1, such a word is always an ordinary program.
- R9: A permitted program or page/partial erase whose address lies outside [FLASH_BASE, FLASH_BASE + N_PAGES·PAGE_BYTES) does not start. Instead it sets `range_err`, which stays set until reset.
- R10: `done` lasts exactly one cycle. `done_op` encodes 1 program, 2 page erase, 3 partial erase, 4 info-page erase and 5 erase-all. `done_page` is 0 for codes 4 and 5. For a program, `done_word` is (address − FLASH_BASE) / 4 and `done_data` is the programmed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for a write or a read |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data of the register at `reg_addr` |
| prog_valid | input | 1 | Program request strobe |
| prog_addr | input | ADDR_W | Byte address of the program request |
| prog_data | input | DATA_W | Word to program |
| ready | output | 1 | No operation is running |
| ready_next | output | 1 | A new request may be issued |
| range_err | output | 1 | Sticky out-of-range flag |
| done | output | 1 | One-cycle completion pulse to the array |
| done_op | output | 3 | Code of the finished operation |
| done_page | output | PAGE_W | Page of the finished erase |
| done_word | output | WORD_W | Word index of the finished program |
| done_data | output | DATA_W | Data of the finished program |

## Verification
Some properties are checked on every cycle. The two status bits always agree. A rising `ready` always comes with a completion pulse. The pulse never lasts longer than one cycle and always carries a legal code. The stored operation code never changes while busy. The range flag never clears. In read-only mode, `ready` never falls.

Other behaviour is shown only by the bench's scenarios, which compare each completion with a scoreboard entry:
- the exact duration of each operation;
- the page and word index arithmetic, including unaligned erase addresses;
- the mode gating of each request type;
- the dropping of requests made while busy;
- the trigger bit-0 rule;
- the all-ones erase alias in the variant without erase registers.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    MODE_RO = 2'd0,
    MODE_WR = 2'd1,
    MODE_ER = 2'd2,
    MODE_PE = 2'd3
  } wen_mode_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PROG = 3'd1,
    OP_PAGE = 3'd2,
    OP_PART = 3'd3,
    OP_INFO = 3'd4,
    OP_ALL  = 3'd5
  } op_e;

  localparam logic [2:0] RA_MODE = 3'd0;
  localparam logic [2:0] RA_PAGE = 3'd1;
  localparam logic [2:0] RA_PART = 3'd2;
  localparam logic [2:0] RA_INFO = 3'd3;
  localparam logic [2:0] RA_ALL  = 3'd4;
  localparam logic [2:0] RA_PCFG = 3'd5;
  localparam logic [2:0] RA_STAT = 3'd6;

endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_seq_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              DATA_W     = 32,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 'h1000,
  parameter int              PAGE_BYTES = 256,
  parameter int              N_PAGES    = 16,
  parameter bit              ERASE_REGS = 1'b1
) (
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              prog_valid,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic              prog_erase,
  input  wen_mode_e         mode,
  output logic              cmd_valid,
  output op_e               cmd_op,
  output logic              cmd_needs_addr,
  output logic              cmd_in_range,
  output logic [$clog2(N_PAGES)-1:0]              cmd_page,
  output logic [$clog2(PAGE_BYTES*N_PAGES/4)-1:0] cmd_word
);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam int PAGE_W     = $clog2(N_PAGES);
  localparam int WORD_W     = $clog2(PAGE_BYTES*N_PAGES/4);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(PAGE_BYTES*N_PAGES);

  logic              raw_valid;
  op_e               raw_op;
  logic [ADDR_W-1:0] raw_addr;
  logic [ADDR_W-1:0] raw_off;
  wen_mode_e         need_mode;

  always_comb begin
    raw_valid = 1'b0;
    raw_op    = OP_NONE;
    raw_addr  = prog_addr;
    if (reg_we) begin
      case (reg_addr)
        RA_PAGE: if (ERASE_REGS) begin
          raw_valid = 1'b1;
          raw_op    = OP_PAGE;
          raw_addr  = ADDR_W'(reg_wdata);
        end
        RA_PART: if (ERASE_REGS) begin
          raw_valid = 1'b1;
          raw_op    = OP_PART;
          raw_addr  = ADDR_W'(reg_wdata);
        end
        RA_INFO: if (ERASE_REGS && reg_wdata[0]) begin
          raw_valid = 1'b1;
          raw_op    = OP_INFO;
        end
        RA_ALL: if (reg_wdata[0]) begin
          raw_valid = 1'b1;
          raw_op    = OP_ALL;
        end
        default: ;
      endcase
    end else if (prog_valid) begin
      raw_valid = 1'b1;
      if (prog_erase && mode == MODE_ER)      raw_op = OP_PAGE;
      else if (prog_erase && mode == MODE_PE) raw_op = OP_PART;
      else                                    raw_op = OP_PROG;
    end
  end

  always_comb begin
    case (raw_op)
      OP_PROG:                 need_mode = MODE_WR;
      OP_PART:                 need_mode = MODE_PE;
      OP_PAGE, OP_INFO, OP_ALL: need_mode = MODE_ER;
      default:                 need_mode = MODE_RO;
    endcase
  end

  assign raw_off        = raw_addr - FLASH_BASE;
  assign cmd_valid      = raw_valid && (mode == need_mode) && (need_mode != MODE_RO);
  assign cmd_op         = raw_op;
  assign cmd_needs_addr = (raw_op == OP_PROG) || (raw_op == OP_PAGE) || (raw_op == OP_PART);
  assign cmd_in_range   = (raw_addr >= FLASH_BASE) && (raw_off < SPAN);
  assign cmd_page       = raw_off[PAGE_SHIFT +: PAGE_W];
  assign cmd_word       = raw_off[2 +: WORD_W];

endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign busy   = (cnt_q != '0);
  assign expire = (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (busy) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load || busy) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              DATA_W     = 32,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 'h1000,
  parameter int              PAGE_BYTES = 256,
  parameter int              N_PAGES    = 16,
  parameter int              CFG_W      = 8,
  parameter int              CFG_RESET  = 10,
  parameter int              T_WRITE    = 6,
  parameter int              T_PAGE     = 30,
  parameter int              T_ALL      = 60,
  parameter int              PART_UNIT  = 2,
  parameter bit              ERASE_REGS = 1'b1,
  localparam int PAGE_W = $clog2(N_PAGES),
  localparam int WORD_W = $clog2(PAGE_BYTES*N_PAGES/4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              prog_valid,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic              ready,
  output logic              ready_next,
  output logic              range_err,
  output logic              done,
  output logic [2:0]        done_op,
  output logic [PAGE_W-1:0] done_page,
  output logic [WORD_W-1:0] done_word,
  output logic [DATA_W-1:0] done_data
);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam int PART_MAX   = ((1 << CFG_W) - 1) * PART_UNIT;
  localparam int MAX_A      = (T_ALL > T_PAGE) ? T_ALL : T_PAGE;
  localparam int MAX_B      = (MAX_A > T_WRITE) ? MAX_A : T_WRITE;
  localparam int MAX_DUR    = (MAX_B > PART_MAX) ? MAX_B : PART_MAX;
  localparam int CNT_W      = $clog2(MAX_DUR + 1);

  // reset synchronizer: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // erase-alias variant selection
  logic prog_erase;
  if (ERASE_REGS) begin : g_regs
    assign prog_erase = 1'b0;
  end else begin : g_alias
    logic [ADDR_W-1:0] poff;
    assign poff       = prog_addr - FLASH_BASE;
    assign prog_erase = (&prog_data) && (poff[PAGE_SHIFT-1:0] == '0);
  end

  logic              cmd_valid, cmd_needs_addr, cmd_in_range;
  op_e               cmd_op;
  logic [PAGE_W-1:0] cmd_page;
  logic [WORD_W-1:0] cmd_word;
  wen_mode_e         mode_q, mode_d;

  flash_seq_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLASH_BASE(FLASH_BASE),
    .PAGE_BYTES(PAGE_BYTES), .N_PAGES(N_PAGES), .ERASE_REGS(ERASE_REGS)
  ) u_decode (
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .prog_valid(prog_valid), .prog_addr(prog_addr), .prog_erase(prog_erase),
    .mode(mode_q), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_needs_addr(cmd_needs_addr), .cmd_in_range(cmd_in_range),
    .cmd_page(cmd_page), .cmd_word(cmd_word)
  );

  logic             busy, expire, accept, range_hit;
  logic [CNT_W-1:0] dur, part_dur;
  logic [CFG_W-1:0] pcfg_q, pcfg_d;
  logic             err_q, err_d, rn_q, rn_d, done_q;
  op_e              op_q, op_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [DATA_W-1:0] data_q, data_d;

  assign accept    = cmd_valid && !busy && (!cmd_needs_addr || cmd_in_range);
  assign range_hit = cmd_valid && !busy && cmd_needs_addr && !cmd_in_range;
  assign part_dur  = CNT_W'(pcfg_q) * CNT_W'(PART_UNIT);

  always_comb begin
    case (cmd_op)
      OP_PROG:          dur = CNT_W'(T_WRITE);
      OP_PAGE, OP_INFO: dur = CNT_W'(T_PAGE);
      OP_ALL:           dur = CNT_W'(T_ALL);
      OP_PART:          dur = (part_dur == '0) ? CNT_W'(1) : part_dur;
      default:          dur = CNT_W'(1);
    endcase
  end

  flash_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .load(accept), .load_val(dur),
    .busy(busy), .expire(expire)
  );

  // next-state process
  always_comb begin
    mode_d = mode_q;
    pcfg_d = pcfg_q;
    err_d  = err_q;
    rn_d   = rn_q;
    op_d   = op_q;
    page_d = page_q;
    word_d = word_q;
    data_d = data_q;
    if (reg_we && reg_addr == RA_MODE) mode_d = wen_mode_e'(reg_wdata[1:0]);
    if (reg_we && reg_addr == RA_PCFG) pcfg_d = reg_wdata[CFG_W-1:0];
    if (range_hit) err_d = 1'b1;
    if (expire)    rn_d  = 1'b1;
    if (accept) begin
      rn_d   = 1'b0;
      op_d   = cmd_op;
      page_d = cmd_needs_addr ? cmd_page : '0;
      word_d = cmd_word;
      data_d = prog_data;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= MODE_RO;
      pcfg_q <= CFG_W'(CFG_RESET);
      err_q  <= 1'b0;
      rn_q   <= 1'b1;
      op_q   <= OP_NONE;
      page_q <= '0;
      word_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (reg_we)           mode_q <= mode_d;
      if (reg_we)           pcfg_q <= pcfg_d;
      if (range_hit)        err_q  <= err_d;
      if (accept || expire) rn_q   <= rn_d;
      if (accept) begin
        op_q   <= op_d;
        page_q <= page_d;
        word_q <= word_d;
        data_q <= data_d;
      end
      done_q <= expire;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_MODE: reg_rdata = DATA_W'(2'(mode_q));
      RA_PCFG: reg_rdata = DATA_W'(pcfg_q);
      RA_STAT: reg_rdata = DATA_W'({err_q, rn_q, ready});
      default: reg_rdata = '0;
    endcase
  end

  assign ready      = !busy;
  assign ready_next = rn_q;
  assign range_err  = err_q;
  assign done       = done_q;
  assign done_op    = 3'(op_q);
  assign done_page  = page_q;
  assign done_word  = word_q;
  assign done_data  = data_q;

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       ready_next,
  input logic       done,
  input logic [2:0] done_op,
  input logic       range_err,
  input logic [1:0] mode,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic [2:0] op_q
);
  // R4
  ready_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready == ready_next);

  // R4
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_op >= 3'd1 && done_op <= 3'd5));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |=> range_err);

  // R2
  ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && mode == 2'd0 && !(reg_we && reg_addr == 3'd0)) |=> ready);

  // R3
  busy_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(op_q));

endmodule

bind flash_cmd_seq flash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ready(ready), .ready_next(ready_next),
  .done(done), .done_op(done_op), .range_err(range_err), .mode(mode_q),
  .reg_we(reg_we), .reg_addr(reg_addr), .op_q(op_q)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  localparam int T_WRITE = 6, T_PAGE = 30, T_ALL = 60, PART_UNIT = 2;
  localparam logic [31:0] BASE = 32'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic a_we = 0, a_pv = 0;  logic [2:0] a_ra = 0;
  logic [31:0] a_wd = 0, a_pa = 0, a_pd = 0, a_rd, a_dt;
  logic a_rdy, a_rn, a_err, a_done; logic [2:0] a_op; logic [3:0] a_pg; logic [9:0] a_wo;
  logic b_we = 0, b_pv = 0;  logic [2:0] b_ra = 0;
  logic [31:0] b_wd = 0, b_pa = 0, b_pd = 0, b_rd, b_dt;
  logic b_rdy, b_rn, b_err, b_done; logic [2:0] b_op; logic [3:0] b_pg; logic [9:0] b_wo;

  flash_cmd_seq #(.FLASH_BASE(BASE), .T_WRITE(T_WRITE), .T_PAGE(T_PAGE), .T_ALL(T_ALL),
    .PART_UNIT(PART_UNIT), .ERASE_REGS(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(a_we), .reg_addr(a_ra), .reg_wdata(a_wd),
    .reg_rdata(a_rd), .prog_valid(a_pv), .prog_addr(a_pa), .prog_data(a_pd),
    .ready(a_rdy), .ready_next(a_rn), .range_err(a_err), .done(a_done),
    .done_op(a_op), .done_page(a_pg), .done_word(a_wo), .done_data(a_dt));

  flash_cmd_seq #(.FLASH_BASE(BASE), .T_WRITE(T_WRITE), .T_PAGE(T_PAGE), .T_ALL(T_ALL),
    .PART_UNIT(PART_UNIT), .ERASE_REGS(1'b0)) dut_nr (
    .clk(clk), .rst_n(rst_n), .reg_we(b_we), .reg_addr(b_ra), .reg_wdata(b_wd),
    .reg_rdata(b_rd), .prog_valid(b_pv), .prog_addr(b_pa), .prog_data(b_pd),
    .ready(b_rdy), .ready_next(b_rn), .range_err(b_err), .done(b_done),
    .done_op(b_op), .done_page(b_pg), .done_word(b_wo), .done_data(b_dt));

  typedef struct { int op; int page; int word; logic [31:0] data; int due; } exp_t;
  exp_t q_a[$];
  exp_t q_b[$];
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input bit sel, input int op, input int page, input int word,
                      input logic [31:0] data, input int due);
    exp_t e;
    e.op = op; e.page = page; e.word = word; e.data = data; e.due = due;
    if (!sel) q_a.push_back(e); else q_b.push_back(e);
  endtask

  task automatic wr(input bit sel, input logic [2:0] a, input logic [31:0] d, output int acc);
    @(negedge clk);
    if (!sel) begin a_we = 1; a_ra = a; a_wd = d; end
    else      begin b_we = 1; b_ra = a; b_wd = d; end
    acc = cyc + 1;
    @(negedge clk);
    a_we = 0; b_we = 0;
  endtask

  task automatic prog(input bit sel, input logic [31:0] a, input logic [31:0] d, output int acc);
    @(negedge clk);
    if (!sel) begin a_pv = 1; a_pa = a; a_pd = d; end
    else      begin b_pv = 1; b_pa = a; b_pd = d; end
    acc = cyc + 1;
    @(negedge clk);
    a_pv = 0; b_pv = 0;
  endtask

  task automatic rd(input bit sel, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    if (!sel) a_ra = a; else b_ra = a;
    #1;
    d = sel ? b_rd : a_rd;
  endtask

  task automatic drain(input bit sel);
    while ((sel ? q_b.size() : q_a.size()) != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input exp_t e, input string who, input logic rdy, input logic rn,
                         input logic [2:0] op, input logic [3:0] pg, input logic [9:0] wo,
                         input logic [31:0] dt);
    check(op == 3'(e.op), {who, " R10 op code"}, 32'(op), 32'(e.op));
    check(cyc == e.due, {who, " R6 duration"}, 32'(cyc), 32'(e.due));
    check(pg == 4'(e.page), {who, " R7 page index"}, 32'(pg), 32'(e.page));
    check(rdy && rn, {who, " R4 ready pair at done"}, {30'd0, rdy, rn}, 32'd3);
    if (e.op == 1) begin
      check(wo == 10'(e.word), {who, " R10 word index"}, 32'(wo), 32'(e.word));
      check(dt == e.data, {who, " R10 data"}, dt, e.data);
    end
  endtask

  // monitor: pops expected completions as the designs produce them
  always @(negedge clk) begin
    if (!finished && rst_n) begin
      if (a_done) begin
        if (q_a.size() == 0) check(1'b0, "dut R3 unexpected done", 32'(a_op), 0);
        else compare(q_a.pop_front(), "dut", a_rdy, a_rn, a_op, a_pg, a_wo, a_dt);
      end
      if (b_done) begin
        if (q_b.size() == 0) check(1'b0, "dut_nr R8 unexpected done", 32'(b_op), 0);
        else compare(q_b.pop_front(), "dut_nr", b_rdy, b_rn, b_op, b_pg, b_wo, b_dt);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int acc;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(a_rdy && a_rn && !a_err, "R1 reset outputs", {29'd0, a_err, a_rn, a_rdy}, 32'd3);
    rd(0, 3'd0, v); check(v == 0, "R1 mode reset", v, 0);
    rd(0, 3'd5, v); check(v == 10, "R1 partial cfg reset", v, 10);
    rd(0, 3'd6, v); check(v == 3, "R1 status reset", v, 3);

    // R2 read-only mode drops a program
    prog(0, BASE + 32'h10, 32'h0, acc);
    check(a_rdy, "R2 program in read-only", 32'(a_rdy), 1);

    // R10/R6/R4 program in write mode
    wr(0, 3'd0, 32'd1, acc);
    prog(0, BASE + 32'h104, 32'h1234_5678, acc);
    push(0, 1, 1, 32'h41, 32'h1234_5678, acc + T_WRITE);
    check(!a_rdy && !a_rn, "R4 busy after accept", {30'd0, a_rdy, a_rn}, 0);
    drain(0);

    // R2 page erase refused in write mode
    wr(0, 3'd1, BASE + 32'h200, acc);
    check(a_rdy, "R2 erase in write mode", 32'(a_rdy), 1);

    // R7 unaligned page erase; R3 requests while busy are dropped
    wr(0, 3'd0, 32'd2, acc);
    wr(0, 3'd1, BASE + 32'h2A0, acc);
    push(0, 2, 2, 0, 0, acc + T_PAGE);
    wr(0, 3'd4, 32'd1, acc);
    wr(0, 3'd1, BASE + 32'h500, acc);
    check(!a_rdy, "R3 still busy with first erase", 32'(a_rdy), 0);
    drain(0);

    // R5 trigger bit 0 only, reads zero
    wr(0, 3'd3, 32'd2, acc);
    check(a_rdy, "R5 info trigger bit0 clear", 32'(a_rdy), 1);
    wr(0, 3'd3, 32'd3, acc);
    push(0, 4, 0, 0, 0, acc + T_PAGE);
    rd(0, 3'd3, v); check(v == 0, "R5 info trigger readback", v, 0);
    drain(0);
    wr(0, 3'd4, 32'hFFFF_FFFE, acc);
    check(a_rdy, "R5 erase-all bit0 clear", 32'(a_rdy), 1);
    wr(0, 3'd4, 32'd1, acc);
    push(0, 5, 0, 0, 0, acc + T_ALL);
    rd(0, 3'd4, v); check(v == 0, "R5 erase-all readback", v, 0);
    drain(0);

    // R6 partial erase duration from config; R2 page erase refused in mode 3
    wr(0, 3'd0, 32'd3, acc);
    wr(0, 3'd5, 32'd5, acc);
    wr(0, 3'd1, BASE + 32'h100, acc);
    check(a_rdy, "R2 page erase in partial mode", 32'(a_rdy), 1);
    wr(0, 3'd2, BASE + 32'h500, acc);
    push(0, 3, 5, 0, 0, acc + 5 * PART_UNIT);
    drain(0);

    // R9 out-of-range erase
    wr(0, 3'd0, 32'd2, acc);
    wr(0, 3'd1, BASE + 32'h1000, acc);
    check(a_rdy && a_err, "R9 range error, no start", {30'd0, a_err, a_rdy}, 3);
    wr(0, 3'd1, BASE + 32'hF00, acc);
    push(0, 2, 15, 0, 0, acc + T_PAGE);
    drain(0);
    rd(0, 3'd6, v); check(v == 7, "R9 error sticky in status", v, 7);

    // R8 all-ones word is a plain program with erase registers
    wr(0, 3'd0, 32'd1, acc);
    prog(0, BASE + 32'h300, 32'hFFFF_FFFF, acc);
    push(0, 1, 3, 32'hC0, 32'hFFFF_FFFF, acc + T_WRITE);
    drain(0);

    // R8 alias variant
    wr(1, 3'd0, 32'd2, acc);
    wr(1, 3'd1, BASE + 32'h100, acc);
    check(b_rdy, "R8 erase register absent", 32'(b_rdy), 1);
    prog(1, BASE + 32'h300, 32'hFFFF_FFFF, acc);
    push(1, 2, 3, 0, 0, acc + T_PAGE);
    drain(1);
    wr(1, 3'd0, 32'd3, acc);
    prog(1, BASE + 32'h400, 32'hFFFF_FFFF, acc);
    push(1, 3, 4, 0, 0, acc + 10 * PART_UNIT);
    drain(1);
    prog(1, BASE + 32'h404, 32'hFFFF_FFFF, acc);
    check(b_rdy, "R8 unaligned all-ones in partial mode", 32'(b_rdy), 1);
    wr(1, 3'd0, 32'd1, acc);
    prog(1, BASE + 32'h400, 32'hFFFF_FFFF, acc);
    push(1, 1, 4, 32'h100, 32'hFFFF_FFFF, acc + T_WRITE);
    drain(1);

    repeat (T_ALL + 5) @(negedge clk);
    check(q_a.size() == 0 && q_b.size() == 0, "R3 scoreboard empty",
          32'(q_a.size() + q_b.size()), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule